// File: doc/BRIEF.md
# Operand Bypass and Load-Use Interlock Unit

This block resolves data hazards for a five-stage in-order integer pipeline (fetch, decode, execute, memory, writeback). It reads a few fields from the pipeline latches and produces three things. The first is a mux select for each ALU operand. The second is a select that swaps fresh data into the store-data path of the memory stage. The third is an interlock signal. The interlock freezes fetch and decode and puts a no-op into execute. The register file, the ALU, the memories and branch handling sit outside the block. The block sees them only through the latch fields on its ports.

The ALU operand selects are worked out one cycle early, while the consumer is still in decode. They are then registered, so the execute-stage muxes get a select straight from a flop. A producer in the execute latch during decode has moved to the execute/memory latch by the time the consumer executes. A producer in the memory latch has moved to the memory/writeback latch. The store-data select is worked out the same way one stage later. The interlock is combinational, because the front of the pipeline has to freeze in the same cycle as the hazard.

Top module: `fwd_unit`

## Requirements
- R1: While the synchronized reset is active, `alu_a_sel` and `alu_b_sel` read 00 and `st_data_fwd` reads 0, whatever the inputs are. Reset is taken asynchronously and released on the second rising clock edge after `rst_n` goes high.
- R2: The select codes are 00 for the register-file value, 01 for the memory/writeback latch value and 10 for the execute/memory latch value. Code 11 never appears. Take a non-load instruction that writes register r and is exactly one place ahead of the consumer. When the consumer is in execute and reads r on operand A or B, that operand's select is 10 for that cycle.
- R3: Take an instruction that writes r, that sits in the memory/writeback latch while the consumer is in execute, and that is not matched by the execute/memory latch. That operand's select is 01. This holds whether the instruction is an ALU operation or a load.
- R4: If the execute/memory and memory/writeback latches both write the register an operand reads, the select is 10, so the younger value wins.
- R5: Register 0 never produces a forward or an interlock. A latch whose write-enable is low never produces a forward or an interlock either.
- R6: A producer three or more places ahead of the consumer, with no nearer writer of the same register, gives select 00. The register file writes early in the cycle and reads late, so it supplies the value.
- R7: Take a load in the execute latch whose destination is read by the decode instruction, through operand A or through operand B of a non-store. `interlock` is 1 in that same cycle. On the next cycle the operand selects are 00, because a bubble is in execute. The held instruction then executes with select 01 from the load in the memory/writeback latch. One stall cycle occurs in total.
- R8: A store whose data register (`dec_src_b` when `dec_is_store` is 1) is the destination of the load just ahead does not interlock. When the store is in the memory stage and the memory/writeback latch writes its data register, `st_data_fwd` is 1 for that cycle. Otherwise it is 0.
- R9: A store whose address base register (`dec_src_a`) is the destination of the load just ahead interlocks like any other consumer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dec_src_a | input | REG_W | Operand A source register of the decode instruction (0 = none) |
| dec_src_b | input | REG_W | Operand B source register, or store-data register for a store (0 = none) |
| dec_is_store | input | 1 | Decode instruction is a store |
| ex_dst | input | REG_W | Destination register in the execute latch |
| ex_wen | input | 1 | Execute-latch instruction writes a register |
| ex_is_load | input | 1 | Execute-latch instruction is a load |
| ex_is_store | input | 1 | Execute-latch instruction is a store |
| ex_src_b | input | REG_W | Store-data register of the execute-latch instruction |
| mem_dst | input | REG_W | Destination register in the memory latch |
| mem_wen | input | 1 | Memory-latch instruction writes a register |
| alu_a_sel | output | 2 | Registered select for ALU operand A in execute |
| alu_b_sel | output | 2 | Registered select for ALU operand B in execute |
| st_data_fwd | output | 1 | Registered: replace store data in memory with the writeback value |
| interlock | output | 1 | Hold fetch and decode, insert a bubble into execute |

## Verification
The bench runs a short instruction stream through its own pipeline model. The stream covers a back-to-back dependency, a two-apart dependency, a three-apart dependency, two writers of the same register, writes to register 0, and a producer with its write-enable low. A unit with the wrong priority would pick the stale memory/writeback value when both latches match. A unit that forgot the register-0 or write-enable qualifier would forward garbage. Load-use pairs check that exactly one bubble appears and that the held instruction then takes its value from the writeback latch. A unit that kept the execute/memory bypass for loads would hand over an address instead of the loaded data. Load-then-store pairs check that a data dependency moves the value late, into the memory stage, without stalling, while a base-register dependency still stalls. A unit that treated store data like operand B would lose a cycle on every such pair.

// File: rtl/fwd_pkg.sv
package fwd_pkg;

  // Source picked by an operand mux; the encoding is visible at the ports.
  typedef enum logic [1:0] {
    FWD_RF  = 2'b00,
    FWD_WB  = 2'b01,
    FWD_EXM = 2'b10
  } fwd_sel_e;

  localparam int unsigned NUM_OPND = 2;

endpackage

// File: rtl/fwd_rst_sync.sv
module fwd_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_n_sync = chain_q[STAGES-1];

endmodule

// File: rtl/fwd_src_match.sv
module fwd_src_match #(
  parameter int unsigned REG_W = 5
) (
  input  logic [REG_W-1:0] src,
  input  logic [REG_W-1:0] dst,
  input  logic             wen,
  output logic             hit
);

  // Register 0 is hard-wired, so it never counts as a producer.
  always_comb begin
    hit = wen && (dst == src) && (src != '0);
  end

endmodule

// File: rtl/fwd_operand_pick.sv
module fwd_operand_pick
  import fwd_pkg::*;
#(
  parameter int unsigned REG_W = 5
) (
  input  logic [REG_W-1:0] src,
  input  logic [REG_W-1:0] ex_dst,
  input  logic             ex_wen,
  input  logic             ex_is_load,
  input  logic [REG_W-1:0] mem_dst,
  input  logic             mem_wen,
  input  logic             stall,
  output fwd_sel_e         sel_nxt
);

  logic near_wen;
  logic hit_near;
  logic hit_far;

  // A load one place ahead has no data yet at execute time.
  assign near_wen = ex_wen & ~ex_is_load;

  fwd_src_match #(.REG_W(REG_W)) u_near (
    .src (src),
    .dst (ex_dst),
    .wen (near_wen),
    .hit (hit_near)
  );

  fwd_src_match #(.REG_W(REG_W)) u_far (
    .src (src),
    .dst (mem_dst),
    .wen (mem_wen),
    .hit (hit_far)
  );

  always_comb begin
    sel_nxt = FWD_RF;
    if (!stall) begin
      if (hit_near) begin
        sel_nxt = FWD_EXM;
      end else if (hit_far) begin
        sel_nxt = FWD_WB;
      end
    end
  end

endmodule

// File: rtl/fwd_load_interlock.sv
module fwd_load_interlock #(
  parameter int unsigned REG_W = 5
) (
  input  logic [REG_W-1:0] dec_src_a,
  input  logic [REG_W-1:0] dec_src_b,
  input  logic             dec_is_store,
  input  logic [REG_W-1:0] ex_dst,
  input  logic             ex_wen,
  input  logic             ex_is_load,
  output logic             stall
);

  logic load_wen;
  logic hit_a;
  logic hit_b;

  assign load_wen = ex_wen & ex_is_load;

  fwd_src_match #(.REG_W(REG_W)) u_hit_a (
    .src (dec_src_a),
    .dst (ex_dst),
    .wen (load_wen),
    .hit (hit_a)
  );

  fwd_src_match #(.REG_W(REG_W)) u_hit_b (
    .src (dec_src_b),
    .dst (ex_dst),
    .wen (load_wen),
    .hit (hit_b)
  );

  // Store data is caught later in the memory stage, so it never stalls.
  always_comb begin
    stall = hit_a | (hit_b & ~dec_is_store);
  end

endmodule

// File: rtl/fwd_unit.sv
module fwd_unit
  import fwd_pkg::*;
#(
  parameter int unsigned REG_W       = 5,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [REG_W-1:0] dec_src_a,
  input  logic [REG_W-1:0] dec_src_b,
  input  logic             dec_is_store,
  input  logic [REG_W-1:0] ex_dst,
  input  logic             ex_wen,
  input  logic             ex_is_load,
  input  logic             ex_is_store,
  input  logic [REG_W-1:0] ex_src_b,
  input  logic [REG_W-1:0] mem_dst,
  input  logic             mem_wen,
  output logic [1:0]       alu_a_sel,
  output logic [1:0]       alu_b_sel,
  output logic             st_data_fwd,
  output logic             interlock
);

  logic             rst_q;
  logic             stall;
  logic [REG_W-1:0] opnd_src [NUM_OPND];
  fwd_sel_e         sel_d    [NUM_OPND];
  fwd_sel_e         sel_q    [NUM_OPND];
  logic             st_hit;
  logic             st_d;
  logic             st_q;

  fwd_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_q)
  );

  fwd_load_interlock #(.REG_W(REG_W)) u_lock (
    .dec_src_a    (dec_src_a),
    .dec_src_b    (dec_src_b),
    .dec_is_store (dec_is_store),
    .ex_dst       (ex_dst),
    .ex_wen       (ex_wen),
    .ex_is_load   (ex_is_load),
    .stall        (stall)
  );

  assign opnd_src[0] = dec_src_a;
  assign opnd_src[1] = dec_src_b;

  for (genvar g = 0; g < NUM_OPND; g++) begin : g_opnd
    fwd_operand_pick #(.REG_W(REG_W)) u_pick (
      .src        (opnd_src[g]),
      .ex_dst     (ex_dst),
      .ex_wen     (ex_wen),
      .ex_is_load (ex_is_load),
      .mem_dst    (mem_dst),
      .mem_wen    (mem_wen),
      .stall      (stall),
      .sel_nxt    (sel_d[g])
    );

    always_ff @(posedge clk or negedge rst_q) begin
      if (!rst_q) begin
        sel_q[g] <= FWD_RF;
      end else begin
        sel_q[g] <= sel_d[g];
      end
    end
  end

  // Store in execute now, producer one ahead in memory now: both move on a stage.
  fwd_src_match #(.REG_W(REG_W)) u_st (
    .src (ex_src_b),
    .dst (mem_dst),
    .wen (mem_wen),
    .hit (st_hit)
  );

  always_comb begin
    st_d = ex_is_store & st_hit;
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      st_q <= 1'b0;
    end else begin
      st_q <= st_d;
    end
  end

  assign alu_a_sel   = sel_q[0];
  assign alu_b_sel   = sel_q[1];
  assign st_data_fwd = st_q;
  assign interlock   = stall;

endmodule

// File: rtl/fwd_unit_chk.sv
module fwd_unit_chk #(
  parameter int unsigned REG_W = 5
) (
  input logic             clk,
  input logic             rst_sync_n,
  input logic [REG_W-1:0] dec_src_a,
  input logic [REG_W-1:0] dec_src_b,
  input logic             dec_is_store,
  input logic [REG_W-1:0] ex_dst,
  input logic             ex_wen,
  input logic             ex_is_load,
  input logic             ex_is_store,
  input logic             mem_wen,
  input logic [1:0]       alu_a_sel,
  input logic [1:0]       alu_b_sel,
  input logic             st_data_fwd,
  input logic             interlock
);

  logic arm1_q;
  logic arm2_q;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      arm1_q <= 1'b0;
      arm2_q <= 1'b0;
    end else begin
      arm1_q <= 1'b1;
      arm2_q <= arm1_q;
    end
  end

  // R2
  sel_code_chk: assert property (@(posedge clk) disable iff (!arm2_q)
    (alu_a_sel != 2'b11) && (alu_b_sel != 2'b11));

  // R4
  young_wins_chk: assert property (@(posedge clk) disable iff (!arm2_q)
    (ex_wen && !ex_is_load && ex_dst != '0 && dec_src_a == ex_dst && !interlock)
      |=> (alu_a_sel == 2'b10));

  // R5
  no_writer_chk: assert property (@(posedge clk) disable iff (!arm2_q)
    (!ex_wen && !mem_wen) |=> (alu_a_sel == 2'b00 && alu_b_sel == 2'b00 && !st_data_fwd));

  // R7
  bubble_sel_chk: assert property (@(posedge clk) disable iff (!arm2_q)
    interlock |=> (alu_a_sel == 2'b00 && alu_b_sel == 2'b00));

  // R7
  lock_cause_chk: assert property (@(posedge clk) disable iff (!arm2_q)
    interlock |-> (ex_is_load && ex_wen && ex_dst != '0));

  // R7
  opnd_b_lock_chk: assert property (@(posedge clk) disable iff (!arm2_q)
    (ex_is_load && ex_wen && ex_dst != '0 && !dec_is_store && dec_src_b == ex_dst)
      |-> interlock);

  // R8
  st_no_lock_chk: assert property (@(posedge clk) disable iff (!arm2_q)
    (dec_is_store && dec_src_a != ex_dst) |-> !interlock);

  // R8
  st_only_chk: assert property (@(posedge clk) disable iff (!arm2_q)
    !ex_is_store |=> !st_data_fwd);

  // R9
  base_lock_chk: assert property (@(posedge clk) disable iff (!arm2_q)
    (ex_is_load && ex_wen && ex_dst != '0 && dec_src_a == ex_dst) |-> interlock);

endmodule

bind fwd_unit fwd_unit_chk #(.REG_W(REG_W)) u_chk (
  .clk          (clk),
  .rst_sync_n   (rst_q),
  .dec_src_a    (dec_src_a),
  .dec_src_b    (dec_src_b),
  .dec_is_store (dec_is_store),
  .ex_dst       (ex_dst),
  .ex_wen       (ex_wen),
  .ex_is_load   (ex_is_load),
  .ex_is_store  (ex_is_store),
  .mem_wen      (mem_wen),
  .alu_a_sel    (alu_a_sel),
  .alu_b_sel    (alu_b_sel),
  .st_data_fwd  (st_data_fwd),
  .interlock    (interlock)
);

// File: tb/fwd_unit_test.sv
module fwd_unit_test;

  localparam int RW = 5;
  localparam int NP = 23;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [RW-1:0] dec_src_a, dec_src_b, ex_dst, ex_src_b, mem_dst;
  logic          dec_is_store, ex_wen, ex_is_load, ex_is_store, mem_wen;
  logic [1:0]    alu_a_sel, alu_b_sel;
  logic          st_data_fwd, interlock;

  always #4 clk = ~clk;

  fwd_unit #(.REG_W(RW)) uut (
    .clk(clk), .rst_n(rst_n),
    .dec_src_a(dec_src_a), .dec_src_b(dec_src_b), .dec_is_store(dec_is_store),
    .ex_dst(ex_dst), .ex_wen(ex_wen), .ex_is_load(ex_is_load),
    .ex_is_store(ex_is_store), .ex_src_b(ex_src_b),
    .mem_dst(mem_dst), .mem_wen(mem_wen),
    .alu_a_sel(alu_a_sel), .alu_b_sel(alu_b_sel),
    .st_data_fwd(st_data_fwd), .interlock(interlock)
  );

  typedef struct {
    int dst; int sa; int sb; bit wen; bit ld; bit st;
  } ins_t;

  typedef struct {
    int exp_a; int exp_b; int exp_st;
    string tag_a; string tag_b;
  } exp_t;

  ins_t prog [NP];
  exp_t sbq [$];
  int   checks = 0;
  int   fails  = 0;
  int   d = -1, e = -1, m = -1, w = -1, pc = 0;

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic bit writes(int k, int r);
    return (k >= 0) && prog[k].wen && (prog[k].dst == r) && (r != 0);
  endfunction

  // Expected select for an execute-stage source, from latch occupancy.
  function automatic int exp_sel(int s);
    if (e < 0 || s == 0) return 0;
    if (writes(m, s) && !prog[m].ld) return 2;
    if (writes(w, s)) return 1;
    return 0;
  endfunction

  function automatic string sel_tag(int s, int code);
    if (e < 0) return "R7";
    if (code == 2) return writes(w, s) ? "R4" : "R2";
    if (code == 1) return prog[w].ld ? "R7" : "R3";
    if (s == 0) return "R5";
    if (m >= 0 && prog[m].dst == s && !prog[m].wen) return "R5";
    return "R6";
  endfunction

  task automatic put(int k, int dst, int sa, int sb, bit wen, bit ld, bit st);
    prog[k].dst = dst; prog[k].sa = sa; prog[k].sb = sb;
    prog[k].wen = wen; prog[k].ld = ld; prog[k].st = st;
  endtask

  task automatic drive();
    dec_src_a    = (d >= 0) ? RW'(prog[d].sa) : '0;
    dec_src_b    = (d >= 0) ? RW'(prog[d].sb) : '0;
    dec_is_store = (d >= 0) ? prog[d].st : 1'b0;
    ex_dst       = (e >= 0) ? RW'(prog[e].dst) : '0;
    ex_wen       = (e >= 0) ? prog[e].wen : 1'b0;
    ex_is_load   = (e >= 0) ? prog[e].ld : 1'b0;
    ex_is_store  = (e >= 0) ? prog[e].st : 1'b0;
    ex_src_b     = (e >= 0) ? RW'(prog[e].sb) : '0;
    mem_dst      = (m >= 0) ? RW'(prog[m].dst) : '0;
    mem_wen      = (m >= 0) ? prog[m].wen : 1'b0;
  endtask

  // Driver: checks the interlock, advances the model, queues expectations.
  task automatic step();
    bit    stall_exp;
    string ltag;
    exp_t  x;
    @(negedge clk);
    stall_exp = 1'b0;
    if (d >= 0 && e >= 0 && prog[e].ld) begin
      stall_exp = writes(e, prog[d].sa) || (!prog[d].st && writes(e, prog[d].sb));
    end
    if (stall_exp && prog[d].st) ltag = "R9";
    else if (d >= 0 && prog[d].st) ltag = "R8";
    else ltag = "R7";
    chk(ltag, "interlock", int'(interlock), int'(stall_exp));
    w = m;
    m = e;
    e = stall_exp ? -1 : d;
    if (!stall_exp) begin
      if (pc < NP) begin d = pc; pc++; end else d = -1;
    end
    drive();
    x.exp_a  = exp_sel((e >= 0) ? prog[e].sa : 0);
    x.exp_b  = exp_sel((e >= 0) ? prog[e].sb : 0);
    x.tag_a  = sel_tag((e >= 0) ? prog[e].sa : 0, x.exp_a);
    x.tag_b  = sel_tag((e >= 0) ? prog[e].sb : 0, x.exp_b);
    x.exp_st = (m >= 0 && prog[m].st && writes(w, prog[m].sb)) ? 1 : 0;
    sbq.push_back(x);
  endtask

  // Monitor: compares registered outputs against queued expectations.
  initial begin
    exp_t y;
    forever begin
      @(negedge clk);
      #1;
      while (sbq.size() > 0) begin
        y = sbq.pop_front();
        chk(y.tag_a, "alu_a_sel", int'(alu_a_sel), y.exp_a);
        chk(y.tag_b, "alu_b_sel", int'(alu_b_sel), y.exp_b);
        chk("R8", "st_data_fwd", int'(st_data_fwd), y.exp_st);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    put(0,  1,  2,  3, 1, 0, 0);
    put(1,  4,  1,  5, 1, 0, 0);  // A one ahead -> 10
    put(2,  6,  7,  1, 1, 0, 0);  // B two ahead -> 01
    put(3,  8,  1,  9, 1, 0, 0);  // three ahead -> 00
    put(4, 10,  2,  2, 1, 0, 0);
    put(5, 10,  3,  3, 1, 0, 0);
    put(6, 11, 10, 10, 1, 0, 0);  // both latches match -> 10
    put(7,  0,  1,  1, 1, 0, 0);  // writes r0
    put(8, 12,  0,  0, 1, 0, 0);
    put(9, 13,  2,  3, 0, 0, 0);  // write-enable low
    put(10, 14, 13, 13, 1, 0, 0);
    put(11, 15,  2,  0, 1, 1, 0); // load
    put(12, 16, 15,  3, 1, 0, 0); // load-use on A
    put(13, 17,  3, 15, 1, 0, 0);
    put(14, 18,  3,  0, 1, 1, 0); // load
    put(15,  0,  2, 18, 0, 0, 1); // store data depends on load
    put(16, 19,  2,  0, 1, 1, 0); // load
    put(17,  0, 19,  3, 0, 0, 1); // store base depends on load
    put(18,  0,  2,  0, 1, 1, 0); // load to r0
    put(19, 21,  0,  0, 1, 0, 0);
    put(20, 22,  2,  0, 1, 1, 0); // load
    put(21, 23,  3,  4, 1, 0, 0);
    put(22, 24, 22, 22, 1, 0, 0); // two after load -> 01

    rst_n        = 1'b0;
    dec_src_a    = 5'd7;
    dec_src_b    = 5'd7;
    dec_is_store = 1'b0;
    ex_dst       = 5'd7;
    ex_wen       = 1'b1;
    ex_is_load   = 1'b0;
    ex_is_store  = 1'b1;
    ex_src_b     = 5'd9;
    mem_dst      = 5'd9;
    mem_wen      = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1", "alu_a_sel", int'(alu_a_sel), 0);
    chk("R1", "alu_b_sel", int'(alu_b_sel), 0);
    chk("R1", "st_data_fwd", int'(st_data_fwd), 0);
    rst_n = 1'b1;
    drive();
    repeat (4) @(negedge clk);
    for (int i = 0; i < NP + 10; i++) step();
    repeat (2) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule